// File: doc/BRIEF.md
# Masked Sticky Status Register

This block is a small bank of control and status registers for a multi-channel converter. A host reaches it over a synchronous register bus with an address, write enable, write data, read strobe and read data. It latches overflow events from three converter channels in sticky flags. It shows a clock-ratio error as a live level. It keeps a writable enable (mask) register whose bit positions match the status bits. It also holds a six-bit register that turns on polarity inversion for each of six channels.

A source whose enable bit is 0 cannot set its flag and always reads 0. The overflow flags stay set until the host reads the status register. That read returns the flags and clears them in the same cycle. The clock-error flag has no memory: it follows its input for as long as that input is enabled. A single active-high interrupt line is high whenever any visible status bit is 1.

Top module: `stat_flag_bank`

## Requirements
- R1: After reset, the invert and enable registers are 0, the status register reads 0, `irq` is 0 and `rd_valid` is 0.
- R2: A write to address 0x17 loads write-data bits 5..0 into the invert register. Bit k drives `inv_en[k]` for channel k+1. Reading 0x17 returns that value with bits 7..6 as 0.
- R3: A write to address 0x1A loads the enable register from write-data bits 4..1. Reading 0x1A returns those bits in place, with bits 7..5 and 0 as 0.
- R4: A pulse on `ovf_evt[k]` while enable bit k+1 is 1 sets status bit k+1 (channel k+1). The bit stays 1 until the next status read.
- R5: A read of the status register at 0x19 clears every overflow flag. A second read with no new events returns 0.
- R6: An event whose enable bit is 0 never sets its flag. Clearing an enable bit also discards a flag already held for that source.
- R7: Status bit 4 equals `clk_err_lvl` ANDed with enable bit 4 at the cycle of the read. A status read does not clear it.
- R8: An event in the same cycle as a status read is left out of that read's data. It appears on the following read.
- R9: Writes to 0x19 and to any unmapped address change no register. Unmapped addresses read as 0.
- R10: `irq` is 1 exactly when at least one visible status bit is 1.
- R11: `rd_valid` is 1 in the cycle after each `rd_stb` and 0 otherwise. In that cycle `rd_data` carries the addressed value. It is 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write enable for one cycle |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe for one cycle |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read response strobe |
| ovf_evt | input | 3 | Overflow event per channel, bit 0 = channel 1 |
| clk_err_lvl | input | 1 | Live clock-ratio error level |
| inv_en | output | 6 | Polarity invert enable, bit 0 = channel 1 |
| irq | output | 1 | Interrupt, high while any status bit reads 1 |

## Verification
The clearing read and a new overflow event can land on the same clock edge. If that case is handled badly, the event is lost or leaks into the data being returned. The bench latches one channel first. It then raises the strobe for a status read together with a pulse on a different channel. The returned word must hold only the older channel, and the next read must hold only the newer one.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    // Default register offsets
    localparam int unsigned OFS_INVERT = 32'h17;
    localparam int unsigned OFS_STATUS = 32'h19;
    localparam int unsigned OFS_ENABLE = 32'h1A;

    // Read response sequencer states
    typedef enum logic {
        RD_IDLE    = 1'b0,
        RD_RESPOND = 1'b1
    } rd_state_e;

endpackage

// File: rtl/sfb_ctrl_regs.sv
module sfb_ctrl_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int N_INV  = 6,
    parameter int EN_W   = 4,
    parameter int unsigned INV_ADDR = sfb_pkg::OFS_INVERT,
    parameter int unsigned EN_ADDR  = sfb_pkg::OFS_ENABLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [N_INV-1:0]  inv_q,
    output logic [EN_W-1:0]   en_q
);
    localparam logic [ADDR_W-1:0] A_INV = ADDR_W'(INV_ADDR);
    localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(EN_ADDR);

    logic hit_inv;
    logic hit_en;

    always_comb begin
        hit_inv = wr_en && (addr == A_INV);
        hit_en  = wr_en && (addr == A_EN);
    end

    // Invert register: low N_INV bits of write data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= '0;
        end else if (hit_inv) begin
            inv_q <= wr_data[N_INV-1:0];
        end
    end

    // Enable register: write data bits EN_W..1, status bit 0 reserved
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (hit_en) begin
            en_q <= wr_data[EN_W:1];
        end
    end

endmodule

// File: rtl/sfb_sticky_lane.sv
module sfb_sticky_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic en,
    input  logic clr,
    output logic flag_q
);
    logic kept;

    always_comb begin
        // A clearing read drops the old value; an event in the same cycle survives
        kept = clr ? 1'b0 : flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (!en) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= kept | evt;
        end
    end

endmodule

// File: rtl/sfb_read_fsm.sv
module sfb_read_fsm
    import sfb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int N_INV  = 6,
    parameter int STAT_W = 5,
    parameter int unsigned INV_ADDR  = OFS_INVERT,
    parameter int unsigned STAT_ADDR = OFS_STATUS,
    parameter int unsigned EN_ADDR   = OFS_ENABLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_stb,
    input  logic [N_INV-1:0]  inv_q,
    input  logic [STAT_W-2:0] en_q,
    input  logic [STAT_W-1:0] stat_view,
    output logic              clr_stat,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam logic [ADDR_W-1:0] A_INV  = ADDR_W'(INV_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(EN_ADDR);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    // Next state: transitions IDLE->RESPOND and RESPOND->RESPOND on a strobe,
    // otherwise back to IDLE
    always_comb begin
        state_d = RD_IDLE;
        unique case (state_q)
            RD_IDLE:    state_d = rd_stb ? RD_RESPOND : RD_IDLE;
            RD_RESPOND: state_d = rd_stb ? RD_RESPOND : RD_IDLE;
            default:    state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Read multiplexer
    always_comb begin
        word_d   = '0;
        clr_stat = 1'b0;
        if (rd_stb) begin
            if (addr == A_INV) begin
                word_d[N_INV-1:0] = inv_q;
            end else if (addr == A_STAT) begin
                word_d[STAT_W-1:0] = stat_view;
                clr_stat           = 1'b1;
            end else if (addr == A_EN) begin
                word_d[STAT_W-1:1] = en_q;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    // Outputs
    always_comb begin
        rd_valid = 1'b0;
        rd_data  = '0;
        unique case (state_q)
            RD_IDLE: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
            RD_RESPOND: begin
                rd_valid = 1'b1;
                rd_data  = word_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

endmodule

// File: rtl/stat_flag_bank.sv
module stat_flag_bank #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int N_OVF  = 3,
    parameter int N_INV  = 6,
    parameter int unsigned INV_ADDR  = sfb_pkg::OFS_INVERT,
    parameter int unsigned STAT_ADDR = sfb_pkg::OFS_STATUS,
    parameter int unsigned EN_ADDR   = sfb_pkg::OFS_ENABLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [N_OVF-1:0]  ovf_evt,
    input  logic              clk_err_lvl,
    output logic [N_INV-1:0]  inv_en,
    output logic              irq
);
    // Status layout: bit 0 reserved, bits N_OVF..1 overflow, bit N_OVF+1 clock error
    localparam int STAT_W = N_OVF + 2;
    localparam int EN_W   = STAT_W - 1;

    logic [N_INV-1:0]  inv_q;
    logic [EN_W-1:0]   en_q;
    logic [N_OVF-1:0]  sticky_q;
    logic [STAT_W-1:0] stat_view;
    logic              clr_stat;

    sfb_ctrl_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .N_INV   (N_INV),
        .EN_W    (EN_W),
        .INV_ADDR(INV_ADDR),
        .EN_ADDR (EN_ADDR)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .inv_q  (inv_q),
        .en_q   (en_q)
    );

    for (genvar k = 0; k < N_OVF; k++) begin : g_lane
        sfb_sticky_lane lane_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (ovf_evt[k]),
            .en    (en_q[k]),
            .clr   (clr_stat),
            .flag_q(sticky_q[k])
        );
    end

    always_comb begin
        stat_view = {clk_err_lvl & en_q[EN_W-1], sticky_q & en_q[N_OVF-1:0], 1'b0};
        irq       = |stat_view;
        inv_en    = inv_q;
    end

    sfb_read_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .N_INV    (N_INV),
        .STAT_W   (STAT_W),
        .INV_ADDR (INV_ADDR),
        .STAT_ADDR(STAT_ADDR),
        .EN_ADDR  (EN_ADDR)
    ) rdfsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .rd_stb   (rd_stb),
        .inv_q    (inv_q),
        .en_q     (en_q),
        .stat_view(stat_view),
        .clr_stat (clr_stat),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
    parameter int ADDR_W = 8,
    parameter int N_OVF  = 3,
    parameter int N_INV  = 6,
    parameter int unsigned STAT_ADDR = sfb_pkg::OFS_STATUS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_stb,
    input logic              rd_valid,
    input logic [N_OVF-1:0]  ovf_evt,
    input logic              clk_err_lvl,
    input logic              irq,
    input logic [N_OVF:0]    en_q,
    input logic [N_INV-1:0]  inv_q,
    input logic [N_OVF-1:0]  sticky_q
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    assert_rd_valid_after_stb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_valid);

    assert_no_valid_without_stb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_valid);

    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && addr == A_STAT && ovf_evt == '0) |=> (sticky_q == '0));

    assert_event_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ovf_evt & en_q[N_OVF-1:0])) |=>
        ((sticky_q & $past(ovf_evt & en_q[N_OVF-1:0])) == $past(ovf_evt & en_q[N_OVF-1:0])));

    assert_collision_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && addr == A_STAT && (|(ovf_evt & en_q[N_OVF-1:0]))) |=> (|sticky_q));

    assert_all_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    assert_clk_err_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_err_lvl && en_q[N_OVF]) |-> irq);

    assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STAT) |=> ($stable(en_q) && $stable(inv_q)));

endmodule

bind stat_flag_bank sfb_checker #(
    .ADDR_W   (ADDR_W),
    .N_OVF    (N_OVF),
    .N_INV    (N_INV),
    .STAT_ADDR(STAT_ADDR)
) checker_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rd_stb     (rd_stb),
    .rd_valid   (rd_valid),
    .ovf_evt    (ovf_evt),
    .clk_err_lvl(clk_err_lvl),
    .irq        (irq),
    .en_q       (en_q),
    .inv_q      (inv_q),
    .sticky_q   (sticky_q)
);

// File: tb/stat_flag_bank_tb_top.sv
`timescale 1ns/1ps
module stat_flag_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic [2:0] ovf_evt = '0;
    logic       clk_err_lvl = 1'b0;
    logic [5:0] inv_en;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    stat_flag_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid),
        .ovf_evt    (ovf_evt),
        .clk_err_lvl(clk_err_lvl),
        .inv_en     (inv_en),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        d = rd_data;
        check("R11 rd_valid", {7'd0, rd_valid}, 8'h01);
    endtask

    task automatic pulse(input logic [2:0] v);
        @(negedge clk);
        ovf_evt = v;
        @(negedge clk);
        ovf_evt = '0;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        @(negedge clk);
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 inv_en", {2'd0, inv_en}, 8'h00);
        rd_reg(8'h1A, d); check("R1 enable", d, 8'h00);
        clk_err_lvl = 1'b1;
        pulse(3'b111);
        rd_reg(8'h19, d); check("R1 status masked", d, 8'h00);
        check("R1 irq masked", {7'd0, irq}, 8'h00);
        clk_err_lvl = 1'b0;
    endtask

    task automatic t_invert;
        logic [7:0] d;
        wr_reg(8'h17, 8'hFF);
        @(negedge clk);
        check("R2 inv_en all", {2'd0, inv_en}, 8'h3F);
        rd_reg(8'h17, d); check("R2 readback all", d, 8'h3F);
        wr_reg(8'h17, 8'h15);
        rd_reg(8'h17, d); check("R2 readback 0x15", d, 8'h15);
        check("R2 inv_en 0x15", {2'd0, inv_en}, 8'h15);
    endtask

    task automatic t_enable;
        logic [7:0] d;
        wr_reg(8'h1A, 8'hFF);
        rd_reg(8'h1A, d); check("R3 reserved bits", d, 8'h1E);
        wr_reg(8'h1A, 8'h0A);
        rd_reg(8'h1A, d); check("R3 partial", d, 8'h0A);
    endtask

    task automatic t_sticky;
        logic [7:0] d;
        wr_reg(8'h1A, 8'h0E);
        pulse(3'b010);
        @(negedge clk);
        check("R10 irq on flag", {7'd0, irq}, 8'h01);
        rd_reg(8'h19, d); check("R4 channel 2", d, 8'h04);
        check("R10 irq after clear", {7'd0, irq}, 8'h00);
        rd_reg(8'h19, d); check("R5 cleared", d, 8'h00);
        pulse(3'b001);
        pulse(3'b100);
        rd_reg(8'h19, d); check("R4 channels 1 and 3", d, 8'h0A);
        rd_reg(8'h19, d); check("R5 cleared again", d, 8'h00);
    endtask

    task automatic t_masked;
        logic [7:0] d;
        wr_reg(8'h1A, 8'h02);
        pulse(3'b110);
        @(negedge clk);
        check("R6 irq masked", {7'd0, irq}, 8'h00);
        rd_reg(8'h19, d); check("R6 masked events", d, 8'h00);
        pulse(3'b001);
        wr_reg(8'h1A, 8'h00);
        wr_reg(8'h1A, 8'h02);
        rd_reg(8'h19, d); check("R6 discarded flag", d, 8'h00);
    endtask

    task automatic t_clkerr;
        logic [7:0] d;
        wr_reg(8'h1A, 8'h10);
        @(negedge clk);
        clk_err_lvl = 1'b1;
        @(negedge clk);
        check("R10 irq clk err", {7'd0, irq}, 8'h01);
        rd_reg(8'h19, d); check("R7 level seen", d, 8'h10);
        rd_reg(8'h19, d); check("R7 not cleared", d, 8'h10);
        clk_err_lvl = 1'b0;
        @(negedge clk);
        check("R7 irq follows", {7'd0, irq}, 8'h00);
        rd_reg(8'h19, d); check("R7 level gone", d, 8'h00);
        wr_reg(8'h1A, 8'h00);
        clk_err_lvl = 1'b1;
        rd_reg(8'h19, d); check("R7 masked level", d, 8'h00);
        clk_err_lvl = 1'b0;
    endtask

    task automatic t_collide;
        logic [7:0] d;
        wr_reg(8'h1A, 8'h0E);
        pulse(3'b001);
        @(negedge clk);
        addr = 8'h19; rd_stb = 1'b1; ovf_evt = 3'b100;
        @(negedge clk);
        rd_stb = 1'b0; ovf_evt = '0;
        check("R8 old data only", rd_data, 8'h02);
        rd_reg(8'h19, d); check("R8 new event kept", d, 8'h08);
    endtask

    task automatic t_ignored;
        logic [7:0] d;
        wr_reg(8'h1A, 8'h06);
        wr_reg(8'h17, 8'h21);
        wr_reg(8'h19, 8'hFF);
        wr_reg(8'h00, 8'hFF);
        wr_reg(8'h18, 8'hFF);
        rd_reg(8'h1A, d); check("R9 enable kept", d, 8'h06);
        rd_reg(8'h17, d); check("R9 invert kept", d, 8'h21);
        rd_reg(8'h19, d); check("R9 status empty", d, 8'h00);
        rd_reg(8'h00, d); check("R9 unmapped 0x00", d, 8'h00);
        rd_reg(8'h18, d); check("R9 unmapped 0x18", d, 8'h00);
    endtask

    task automatic t_rd_timing;
        logic [7:0] d;
        rd_reg(8'h17, d);
        @(negedge clk);
        check("R11 valid drops", {7'd0, rd_valid}, 8'h00);
        check("R11 data zero idle", rd_data, 8'h00);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_invert();
        t_enable();
        t_sticky();
        t_masked();
        t_clkerr();
        t_collide();
        t_ignored();
        t_rd_timing();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule